// File: doc/BRIEF.md
# Paged Address Translator with Per-Page Byte Order

This block sits between a network controller (and the host CPU) and a bank of on-board packet memory. Every access arrives as a 24-bit address. The block looks up one of 1024 page-map slots and builds a physical address from the page frame held in that slot and the 10-bit offset within the page. The host and the controller share the same map. The top four address bits take no part in the lookup, so sixteen 1 MB windows alias onto the same slots.

Each 16-bit map entry holds three fields:
- a frame number, in bits 11..0;
- a location flag, in bit 13;
- an order flag, in bit 15.

The location flag sends the access either to on-board memory or to an auxiliary bus. The order flag decides whether 16-bit data is passed straight through (host order) or has its two byte lanes exchanged (controller order). The exchange applies to write data going out and to read data coming back. On-board memory holds 256 frames of 1 KB. An on-board access that names a frame beyond that range raises an error and issues no memory strobe.

Software fills the map through a single-slot host port. A slot written in one cycle is used by a translation in the next cycle. Software normally points slot 1023 at the same frame as slot 0. The fixed configuration pointer near 0xFFFFF4 then lands in the first page of memory.

Top module: `pgmap_xlate`

## Requirements
- R1: After reset all strobes, the error flag, `ram_we` and `map_rdata` are 0, and every map entry reads back as 0x0000. A translation through a never-written slot therefore uses frame 0, on-board, with lanes swapped.
- R2: The slot index is `xl_addr[19:10]`, and `xl_addr[23:20]` has no effect on the result.
- R3: One clock after a request (`xl_valid`=1), `phys_addr` equals `{frame, xl_addr[9:0]}`, where frame is entry bits 11..0.
- R4: With entry bit 15 clear, `ram_swap` is 1, `ram_wdata` is `{xl_wdata[7:0], xl_wdata[15:8]}` and `xl_rdata` is `{ram_rdata[7:0], ram_rdata[15:8]}`. With bit 15 set, `ram_swap` is 0 and both data paths pass unchanged.
- R5: With entry bit 13 set, the access raises `aux_strobe` and neither `ram_strobe` nor `err_range`, whatever the frame number.
- R6: With entry bit 13 clear and a frame of 256 or more, `err_range` is 1 and `ram_strobe` is 0. Frames 0..255 raise `ram_strobe` and no error.
- R7: A host write (`map_we`=1) stores `map_wdata` into slot `map_slot` at the clock edge. A translation presented in the following cycle uses the new entry, and `map_rdata` shows the entry of `map_slot` one clock after the slot is presented.
- R8: When slots 0 and 1023 hold the same entry, address 0xFFFFF4 and address 0x0003F4 translate to the same physical address.
- R9: One clock after a cycle with `xl_valid`=0, `ram_strobe`, `aux_strobe`, `err_range` and `ram_we` are all 0. `ram_we` follows `xl_we` of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the map and outputs |
| map_we | input | 1 | Host write strobe for one map entry |
| map_slot | input | 10 | Slot addressed by the host port (read and write) |
| map_wdata | input | 16 | Entry value to store |
| map_rdata | output | 16 | Entry of the slot presented one clock earlier |
| xl_valid | input | 1 | Translation request |
| xl_we | input | 1 | Request is a write |
| xl_addr | input | 24 | Controller or host address |
| xl_wdata | input | 16 | Write data in requester order |
| xl_rdata | output | 16 | Read data returned in requester order |
| ram_strobe | output | 1 | On-board memory access |
| aux_strobe | output | 1 | Auxiliary-bus memory access |
| err_range | output | 1 | On-board frame out of range, access blocked |
| ram_we | output | 1 | Access is a write |
| ram_swap | output | 1 | Byte lanes exchanged for this access |
| phys_addr | output | 22 | Frame and offset of the access |
| ram_wdata | output | 16 | Write data in memory order |
| ram_rdata | input | 16 | Read data from memory |

## Verification
The bench targets the following corner cases:
- **Alias of the top nibble.** The same slot is reached with 0x0 and 0xF in the top nibble. A decoder that used those bits would select a different, empty slot and return frame 0.
- **Frame range boundary.** Frames 255 and 256 are both exercised on-board, and frame 256 is also placed on the auxiliary bus. An off-by-one compare, or a range check that forgot the location flag, would strobe the wrong target or flag a legal access.
- **Write-then-use.** A slot rewritten in the cycle just before its use catches a map that needs an extra cycle to settle, because that map would still report the old frame.
- **Double-mapped configuration page and lane order.** The page reached through slots 1023 and 0 is checked, together with both data directions in the two byte orders. This exposes a swap applied to only one direction or with inverted polarity.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
    localparam int VA_W      = 24;
    localparam int SLOT_W    = 10;
    localparam int OFF_W     = 10;
    localparam int ENTRY_W   = 16;
    localparam int FRAME_W   = 12;
    localparam int DATA_W    = 16;
    localparam int NUM_SLOTS = 1 << SLOT_W;
    localparam int PA_W      = FRAME_W + OFF_W;
    localparam int BIT_HOST_ORDER = 15;
    localparam int BIT_AUX        = 13;

    typedef struct packed {
        logic               host_order;
        logic               aux;
        logic [FRAME_W-1:0] frame;
    } map_fields_t;

    typedef struct packed {
        logic               ram_stb;
        logic               aux_stb;
        logic               err;
        logic               swap;
        logic               we;
        logic [PA_W-1:0]    pa;
        logic [DATA_W-1:0]  wdata;
        logic [ENTRY_W-1:0] map_rd;
    } xl_state_t;

    function automatic map_fields_t split_entry(input logic [ENTRY_W-1:0] e);
        map_fields_t f;
        f.host_order = e[BIT_HOST_ORDER];
        f.aux        = e[BIT_AUX];
        f.frame      = e[FRAME_W-1:0];
        return f;
    endfunction
endpackage

// File: rtl/pgmap_store.sv
module pgmap_store #(
    parameter int SLOTS = 1024,
    parameter int W     = 16,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] wslot,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] rslot_a,
    output logic [W-1:0]  rdata_a,
    input  logic [IW-1:0] rslot_b,
    output logic [W-1:0]  rdata_b
);
    logic [SLOTS-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[wslot] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_a = mem_q[rslot_a];
    assign rdata_b = mem_q[rslot_b];
endmodule

// File: rtl/pgmap_lane_swap.sv
module pgmap_lane_swap #(
    parameter int DW  = 16,
    localparam int NB = DW / 8
) (
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign dout[b*8 +: 8] = en ? din[(NB-1-b)*8 +: 8] : din[b*8 +: 8];
    end
endmodule

// File: rtl/pgmap_decode.sv
module pgmap_decode
    import pgmap_pkg::*;
#(
    parameter int ONBOARD_FRAMES = 256
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [OFF_W-1:0]   offset,
    input  logic [DATA_W-1:0]  wdata_in,
    output logic               hit_ram,
    output logic               hit_aux,
    output logic               range_bad,
    output logic               swap,
    output logic [PA_W-1:0]    pa,
    output logic [DATA_W-1:0]  wdata_out
);
    localparam logic [FRAME_W:0] FRAME_LIMIT = (FRAME_W+1)'(ONBOARD_FRAMES);

    map_fields_t f;
    logic        too_high;

    always_comb begin
        f         = split_entry(entry);
        too_high  = {1'b0, f.frame} >= FRAME_LIMIT;
        swap      = !f.host_order;
        hit_aux   = f.aux;
        range_bad = !f.aux && too_high;
        hit_ram   = !f.aux && !too_high;
        pa        = {f.frame, offset};
    end

    pgmap_lane_swap #(.DW(DATA_W)) u_wswap (
        .en   (swap),
        .din  (wdata_in),
        .dout (wdata_out)
    );
endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
#(
    parameter int ONBOARD_FRAMES = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_we,
    input  logic [SLOT_W-1:0]  map_slot,
    input  logic [ENTRY_W-1:0] map_wdata,
    output logic [ENTRY_W-1:0] map_rdata,
    input  logic               xl_valid,
    input  logic               xl_we,
    input  logic [VA_W-1:0]    xl_addr,
    input  logic [DATA_W-1:0]  xl_wdata,
    output logic [DATA_W-1:0]  xl_rdata,
    output logic               ram_strobe,
    output logic               aux_strobe,
    output logic               err_range,
    output logic               ram_we,
    output logic               ram_swap,
    output logic [PA_W-1:0]    phys_addr,
    output logic [DATA_W-1:0]  ram_wdata,
    input  logic [DATA_W-1:0]  ram_rdata
);
    logic [SLOT_W-1:0]  xl_slot;
    logic [ENTRY_W-1:0] xl_entry, host_entry;
    logic               dec_ram, dec_aux, dec_err, dec_swap;
    logic [PA_W-1:0]    dec_pa;
    logic [DATA_W-1:0]  dec_wdata;
    xl_state_t          st_d, st_q;

    // bits above the slot field are dropped, so the windows alias
    assign xl_slot = xl_addr[OFF_W +: SLOT_W];

    pgmap_store #(.SLOTS(NUM_SLOTS), .W(ENTRY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (map_we),
        .wslot   (map_slot),
        .wdata   (map_wdata),
        .rslot_a (xl_slot),
        .rdata_a (xl_entry),
        .rslot_b (map_slot),
        .rdata_b (host_entry)
    );

    pgmap_decode #(.ONBOARD_FRAMES(ONBOARD_FRAMES)) u_decode (
        .entry     (xl_entry),
        .offset    (xl_addr[OFF_W-1:0]),
        .wdata_in  (xl_wdata),
        .hit_ram   (dec_ram),
        .hit_aux   (dec_aux),
        .range_bad (dec_err),
        .swap      (dec_swap),
        .pa        (dec_pa),
        .wdata_out (dec_wdata)
    );

    always_comb begin
        st_d         = st_q;
        st_d.map_rd  = host_entry;
        st_d.ram_stb = 1'b0;
        st_d.aux_stb = 1'b0;
        st_d.err     = 1'b0;
        st_d.we      = 1'b0;
        if (xl_valid) begin
            st_d.ram_stb = dec_ram;
            st_d.aux_stb = dec_aux;
            st_d.err     = dec_err;
            st_d.we      = xl_we;
            st_d.swap    = dec_swap;
            st_d.pa      = dec_pa;
            st_d.wdata   = dec_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read data returns in the cycle the access is on the memory side
    pgmap_lane_swap #(.DW(DATA_W)) u_rswap (
        .en   (st_q.swap),
        .din  (ram_rdata),
        .dout (xl_rdata)
    );

    assign map_rdata  = st_q.map_rd;
    assign ram_strobe = st_q.ram_stb;
    assign aux_strobe = st_q.aux_stb;
    assign err_range  = st_q.err;
    assign ram_we     = st_q.we;
    assign ram_swap   = st_q.swap;
    assign phys_addr  = st_q.pa;
    assign ram_wdata  = st_q.wdata;
endmodule

// File: rtl/pgmap_xlate_chk.sv
module pgmap_xlate_chk
    import pgmap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               xl_valid,
    input logic               xl_we,
    input logic [VA_W-1:0]    xl_addr,
    input logic [DATA_W-1:0]  xl_wdata,
    input logic [DATA_W-1:0]  xl_rdata,
    input logic               ram_strobe,
    input logic               aux_strobe,
    input logic               err_range,
    input logic               ram_we,
    input logic               ram_swap,
    input logic [PA_W-1:0]    phys_addr,
    input logic [DATA_W-1:0]  ram_wdata,
    input logic [DATA_W-1:0]  ram_rdata
);
    assert_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> phys_addr[OFF_W-1:0] == $past(xl_addr[OFF_W-1:0]));

    assert_wswap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_we) |=> (ram_swap ?
            (ram_wdata == {$past(xl_wdata[7:0]), $past(xl_wdata[15:8])}) :
            (ram_wdata == $past(xl_wdata))));

    assert_rswap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_swap |-> xl_rdata == {ram_rdata[7:0], ram_rdata[15:8]});

    assert_rpass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_swap |-> xl_rdata == ram_rdata);

    assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_strobe, aux_strobe, err_range}));

    assert_err_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> !ram_strobe);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid |=> !ram_strobe && !aux_strobe && !err_range && !ram_we);

    assert_we_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> ram_we == $past(xl_we));
endmodule

bind pgmap_xlate pgmap_xlate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xl_valid   (xl_valid),
    .xl_we      (xl_we),
    .xl_addr    (xl_addr),
    .xl_wdata   (xl_wdata),
    .xl_rdata   (xl_rdata),
    .ram_strobe (ram_strobe),
    .aux_strobe (aux_strobe),
    .err_range  (err_range),
    .ram_we     (ram_we),
    .ram_swap   (ram_swap),
    .phys_addr  (phys_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata)
);

// File: tb/tb_pgmap_xlate.sv
`timescale 1ns/1ps
module tb_pgmap_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_we = 1'b0;
    logic [9:0]  map_slot = '0;
    logic [15:0] map_wdata = '0;
    logic [15:0] map_rdata;
    logic        xl_valid = 1'b0;
    logic        xl_we = 1'b0;
    logic [23:0] xl_addr = '0;
    logic [15:0] xl_wdata = '0;
    logic [15:0] xl_rdata;
    logic        ram_strobe, aux_strobe, err_range, ram_we, ram_swap;
    logic [21:0] phys_addr;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = 16'hA55A;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pgmap_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .map_we(map_we), .map_slot(map_slot), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .xl_valid(xl_valid), .xl_we(xl_we), .xl_addr(xl_addr), .xl_wdata(xl_wdata),
        .xl_rdata(xl_rdata), .ram_strobe(ram_strobe), .aux_strobe(aux_strobe),
        .err_range(err_range), .ram_we(ram_we), .ram_swap(ram_swap),
        .phys_addr(phys_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // entry, address, expected physical address, expected {ram,aux,err,swap}
    localparam logic [65:0] VEC [7] = '{
        {16'h8005, 24'h012ABC, 22'h0016BC, 4'b1000},  // R3 host order
        {16'h0007, 24'hF12ABC, 22'h001EBC, 4'b1001},  // R2 R4 alias, swapped
        {16'hA0FF, 24'h000000, 22'h03FC00, 4'b0100},  // R5 aux
        {16'h8100, 24'h0FFFFF, 22'h0403FF, 4'b0010},  // R6 frame 256
        {16'hA100, 24'h000400, 22'h040000, 4'b0100},  // R5 aux frame 256
        {16'h80FF, 24'h7FFC01, 22'h03FC01, 4'b1000},  // R6 frame 255
        {16'h2FFF, 24'h000801, 22'h3FFC01, 4'b0101}   // R5 R4 aux swapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic write_map(input logic [9:0] slot, input logic [15:0] val);
        map_we = 1'b1; map_slot = slot; map_wdata = val;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic do_xl(input logic [23:0] a, input logic we, input logic [15:0] wd);
        xl_valid = 1'b1; xl_addr = a; xl_we = we; xl_wdata = wd;
        @(negedge clk);
        xl_valid = 1'b0; xl_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobes", {ram_strobe, aux_strobe, err_range, ram_we}, 0);
        check("R1 map_rdata", map_rdata, 0);
        map_slot = 10'd1023;
        @(negedge clk);
        check("R1 slot 1023 clear", map_rdata, 0);
        do_xl(24'h001410, 1'b1, 16'h1234);
        check("R1 default phys", phys_addr, 22'h10);
        check("R1 default flags", {ram_strobe, aux_strobe, err_range, ram_swap}, 4'b1001);

        for (int i = 0; i < 7; i++) begin
            logic [15:0] ent;
            logic [23:0] adr;
            logic [21:0] epa;
            logic [3:0]  efl;
            {ent, adr, epa, efl} = VEC[i];
            write_map(adr[19:10], ent);
            do_xl(adr, 1'b1, 16'h1234);
            check($sformatf("R3 vec%0d phys", i), phys_addr, epa);
            check($sformatf("R5 R6 vec%0d flags", i),
                  {ram_strobe, aux_strobe, err_range, ram_swap}, efl);
            check($sformatf("R4 vec%0d wdata", i), ram_wdata, efl[0] ? 16'h3412 : 16'h1234);
            check($sformatf("R4 vec%0d rdata", i), xl_rdata, efl[0] ? 16'h5AA5 : 16'hA55A);
            check($sformatf("R9 vec%0d we", i), ram_we, 1);
        end

        // R9 idle cycle clears strobes
        @(negedge clk);
        check("R9 idle", {ram_strobe, aux_strobe, err_range, ram_we}, 0);
        // R9 read request leaves ram_we low
        do_xl(24'h012ABC, 1'b0, 16'h0);
        check("R9 read we", {ram_strobe, ram_we}, 2'b10);

        // R7 write, read back, then rewrite and use in the very next cycle
        write_map(10'd3, 16'h8009);
        map_slot = 10'd3;
        @(negedge clk);
        check("R7 readback", map_rdata, 16'h8009);
        write_map(10'd3, 16'h800A);
        do_xl(24'h000C05, 1'b0, 16'h0);
        check("R7 new entry used", phys_addr, 22'h2805);

        // R8 configuration page reached through slot 1023 and slot 0
        write_map(10'd0, 16'h8020);
        write_map(10'd1023, 16'h8020);
        do_xl(24'hFFFFF4, 1'b0, 16'h0);
        check("R8 high alias", phys_addr, 22'h83F4);
        do_xl(24'h0003F4, 1'b0, 16'h0);
        check("R8 low alias", phys_addr, 22'h83F4);
        check("R2 R8 flags", {ram_strobe, ram_swap}, 2'b10);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule